// File: doc/BRIEF.md
# Per-Subpage ECC Status Evaluator

After a flash page read, the correction engine leaves a packed result word that describes how many symbols it repaired in each 512-byte subpage. This block takes that word on a start pulse, walks it one subpage per clock and produces two results: the total number of corrected symbols and a flag saying whether any subpage went past what the selected correction strength can repair. A one-cycle done strobe marks the end of the walk. The results stay on the outputs until the next start pulse.

Three interpretations of the result word are supported. There are two per-subpage modes, a 4-symbol mode and an 8-symbol mode. In each of them, every subpage owns a 4-bit field, and the mode decides how much of that field counts and where the limit lies. There is also an older two-code mode, in which the word carries one code for the main area and one for the spare area, and a code of 2 means the data could not be repaired. The correction arithmetic itself is done elsewhere. This block only judges and totals its report.

Top module: `ecc_subpage_eval`

## Requirements
- R1: While reset is asserted and after it is released, corr_total is 0, uncorrectable is 0 and done is 0 until the first walk ends.
- R2: The number of subpages walked is page_bytes divided by 512 (integer division), raised to 1 if the quotient is 0 and cut to MAX_SUB if it is larger. Subpage i reads bits 4i+3..4i of ecc_word. Fields above the last walked subpage have no effect.
- R3: The clock edge that samples start latches all inputs. Each of the following edges handles one subpage, and done is high for exactly one cycle after the edge that handles the last subpage. In two-code mode a single step is taken.
- R4: mode 2'b01 (4-symbol): only bits 2..0 of each field count, and the correction limit is 4.
- R5: mode 2'b10 or 2'b11 (8-symbol): all four bits of each field count, and the correction limit is 8.
- R6: A subpage whose count is above the limit sets uncorrectable and adds nothing to the total. A subpage whose count is at or below the limit adds that count to corr_total.
- R7: mode 2'b00 (two-code): the main-area code is bits 1..0 and the spare-area code is the value of bits W-1..2. If either equals 2, uncorrectable is set. corr_total stays 0.
- R8: A start pulse clears corr_total and uncorrectable. Once set, uncorrectable stays set, and both results hold their values after done, until the next start.
- R9: A start pulse that arrives during a walk abandons that walk and begins a new one with the newly presented inputs. The abandoned walk produces no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to evaluate ecc_word |
| mode | input | 2 | 00 two-code, 01 4-symbol, 10/11 8-symbol |
| page_bytes | input | PAGE_W | Page size in bytes |
| ecc_word | input | 4*MAX_SUB | Packed correction result |
| corr_total | output | CNT_W | Sum of corrected symbols |
| uncorrectable | output | 1 | Some subpage exceeded the limit |
| done | output | 1 | One-cycle end-of-walk strobe |

## Verification
The hardest case to reach from the ports is a start pulse that lands partway through a walk. For that case the bench has to show that the old walk never raises done and that the new walk's latency is counted from the second pulse. The bench launches an eight-subpage walk and fires a second start two cycles later with a short page and a different word. It then checks the latency and the results against the second word alone. Limit boundaries are reached with hand-placed nibble values: 4 and 5 in the 4-symbol mode, 8 and 9 in the 8-symbol mode, and high bits that the 3-bit mask must hide.

// File: rtl/ecc_eval_pkg.sv
package ecc_eval_pkg;

  localparam logic [1:0] MODE_TWO_CODE = 2'b00;
  localparam logic [1:0] MODE_SYM4     = 2'b01;

  // Symbols counted for one subpage field under the selected mode
  function automatic logic [3:0] field_errs(input logic [3:0] nib, input logic [1:0] mode);
    return (mode == MODE_SYM4) ? {1'b0, nib[2:0]} : nib;
  endfunction

  // Largest count that is still repairable in the selected mode
  function automatic logic [3:0] field_limit(input logic [1:0] mode);
    return (mode == MODE_SYM4) ? 4'd4 : 4'd8;
  endfunction

endpackage

// File: rtl/ecc_walk_ctrl.sv
module ecc_walk_ctrl
  import ecc_eval_pkg::*;
#(
  parameter int MAX_SUB = 8,
  parameter int PAGE_W  = 16,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [PAGE_W-1:0] page_bytes,
  output logic [IDX_W-1:0]  idx,
  output logic              step,
  output logic              last,
  output logic [1:0]        mode_q,
  output logic              legacy_q,
  output logic              done
);
  localparam int RAW_W = PAGE_W - 9;

  logic [RAW_W-1:0] raw_sub;
  logic [IDX_W-1:0] last_idx_d, last_idx_q;
  logic             active;

  assign raw_sub = page_bytes[PAGE_W-1:9];

  always_comb begin
    if (mode == MODE_TWO_CODE || raw_sub == '0)
      last_idx_d = '0;
    else if (int'(raw_sub) >= MAX_SUB)
      last_idx_d = IDX_W'(MAX_SUB - 1);
    else
      last_idx_d = IDX_W'(raw_sub - RAW_W'(1));
  end

  assign step     = active;
  assign last     = active && (idx == last_idx_q);
  assign legacy_q = (mode_q == MODE_TWO_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      idx        <= '0;
      last_idx_q <= '0;
      mode_q     <= '0;
      done       <= 1'b0;
    end else if (start) begin
      active     <= 1'b1;
      idx        <= '0;
      last_idx_q <= last_idx_d;
      mode_q     <= mode;
      done       <= 1'b0;
    end else begin
      done <= step && last;
      if (active) begin
        if (last) active <= 1'b0;
        else      idx    <= idx + IDX_W'(1);
      end
    end
  end

  assert_last_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !start) |=> done);
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/ecc_field_sel.sv
module ecc_field_sel #(
  parameter int MAX_SUB = 8,
  parameter int IDX_W   = 3
) (
  input  logic [4*MAX_SUB-1:0] word,
  input  logic [IDX_W-1:0]     idx,
  output logic [3:0]           nib
);
  logic [3:0] fields [MAX_SUB];

  for (genvar g = 0; g < MAX_SUB; g++) begin : g_field
    assign fields[g] = word[4*g +: 4];
  end

  assign nib = fields[idx];

endmodule

// File: rtl/ecc_field_judge.sv
module ecc_field_judge
  import ecc_eval_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [3:0]        nib,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] word,
  output logic [3:0]        add_val,
  output logic              bad
);
  logic [3:0]        errs;
  logic [1:0]        main_code;
  logic [WORD_W-3:0] spare_code;
  logic              two_code_bad;

  assign errs         = field_errs(nib, mode);
  assign main_code    = word[1:0];
  assign spare_code   = word[WORD_W-1:2];
  assign two_code_bad = (main_code == 2'd2) || (spare_code == (WORD_W-2)'(2));

  always_comb begin
    if (mode == MODE_TWO_CODE) begin
      bad     = two_code_bad;
      add_val = '0;
    end else begin
      bad     = errs > field_limit(mode);
      add_val = bad ? 4'd0 : errs;
    end
  end

endmodule

// File: rtl/ecc_subpage_eval.sv
module ecc_subpage_eval
  import ecc_eval_pkg::*;
#(
  parameter int MAX_SUB  = 8,
  parameter int PAGE_W   = 16,
  localparam int WORD_W  = 4 * MAX_SUB,
  localparam int CNT_W   = $clog2(MAX_SUB * 8 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [PAGE_W-1:0] page_bytes,
  input  logic [WORD_W-1:0] ecc_word,
  output logic [CNT_W-1:0]  corr_total,
  output logic              uncorrectable,
  output logic              done
);
  localparam int IDX_W = (MAX_SUB > 1) ? $clog2(MAX_SUB) : 1;

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx;
  logic              step, last, legacy_q;
  logic [1:0]        mode_q;
  logic [3:0]        nib, add_val;
  logic              bad;

  ecc_walk_ctrl #(.MAX_SUB(MAX_SUB), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .page_bytes(page_bytes),
    .idx(idx), .step(step), .last(last), .mode_q(mode_q), .legacy_q(legacy_q),
    .done(done)
  );

  ecc_field_sel #(.MAX_SUB(MAX_SUB), .IDX_W(IDX_W)) u_sel (
    .word(word_q), .idx(idx), .nib(nib)
  );

  ecc_field_judge #(.WORD_W(WORD_W)) u_judge (
    .nib(nib), .mode(mode_q), .word(word_q), .add_val(add_val), .bad(bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q        <= '0;
      corr_total    <= '0;
      uncorrectable <= 1'b0;
    end else if (start) begin
      word_q        <= ecc_word;
      corr_total    <= '0;
      uncorrectable <= 1'b0;
    end else if (step) begin
      corr_total <= corr_total + CNT_W'(add_val);
      if (bad) uncorrectable <= 1'b1;
    end
  end

  assert_clear_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (corr_total == '0 && !uncorrectable));
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (uncorrectable && !start) |=> uncorrectable);
  assert_total_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (corr_total >= $past(corr_total)));
  assert_two_code_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_q |-> (corr_total == '0));
  assert_sym4_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode_q == MODE_SYM4) |-> (add_val <= 4'd4));

endmodule

// File: tb/test_ecc_subpage_eval.sv
`timescale 1ns/100ps
module test_ecc_subpage_eval;
  localparam int MAX_SUB = 8;
  localparam int PAGE_W  = 16;
  localparam int WORD_W  = 4 * MAX_SUB;
  localparam int CNT_W   = $clog2(MAX_SUB * 8 + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        mode = 2'b10;
  logic [PAGE_W-1:0] page_bytes = '0;
  logic [WORD_W-1:0] ecc_word = '0;
  logic [CNT_W-1:0]  corr_total;
  logic              uncorrectable;
  logic              done;

  int checks = 0;
  int fails  = 0;
  int got_lat, got_tot, got_bad;

  always #2.5 clk = ~clk;

  ecc_subpage_eval #(.MAX_SUB(MAX_SUB), .PAGE_W(PAGE_W)) i_ecc_subpage_eval (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .page_bytes(page_bytes),
    .ecc_word(ecc_word), .corr_total(corr_total), .uncorrectable(uncorrectable),
    .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int n_subs(input int md, input int bytes);
    int n = bytes / 512;
    if (md == 0) return 1;
    if (n < 1) n = 1;
    if (n > MAX_SUB) n = MAX_SUB;
    return n;
  endfunction

  // Reference judgement written from the requirements
  task automatic model(input int md, input int bytes, input logic [WORD_W-1:0] w,
                       output int tot, output int bad);
    tot = 0; bad = 0;
    if (md == 0) begin
      if (w[1:0] == 2'd2 || (w >> 2) == 2) bad = 1;
    end else begin
      for (int i = 0; i < n_subs(md, bytes); i++) begin
        int v = int'(w[4*i +: 4]);
        int lim = 8;
        if (md == 1) begin v = v % 8; lim = 4; end
        if (v > lim) bad = 1; else tot += v;
      end
    end
  endtask

  task automatic launch(input int md, input int bytes, input logic [WORD_W-1:0] w);
    @(negedge clk);
    mode = 2'(md); page_bytes = PAGE_W'(bytes); ecc_word = w; start = 1'b1;
  endtask

  task automatic await_done();
    got_lat = 0;
    do begin
      @(negedge clk);
      got_lat++;
      if (got_lat == 1) start = 1'b0;
    end while (!done && got_lat < 40);
    got_tot = int'(corr_total);
    got_bad = int'(uncorrectable);
    @(negedge clk);
    chk(!done, "R3 done one cycle", int'(done), 0);
  endtask

  task automatic run_and_check(input string tag, input int md, input int bytes,
                               input logic [WORD_W-1:0] w);
    int et, eb;
    model(md, bytes, w, et, eb);
    launch(md, bytes, w);
    await_done();
    chk(got_lat == n_subs(md, bytes) + 1, {tag, " latency R3"}, got_lat, n_subs(md, bytes) + 1);
    chk(got_tot == et, {tag, " total"}, got_tot, et);
    chk(got_bad == eb, {tag, " flag"}, got_bad, eb);
  endtask

  task automatic t_reset();
    chk(corr_total == 0, "R1 total", int'(corr_total), 0);
    chk(!uncorrectable, "R1 flag", int'(uncorrectable), 0);
    chk(!done, "R1 done", int'(done), 0);
  endtask

  task automatic t_sym8();
    run_and_check("R5 R6 sym8 sum", 2, 2048, 32'h0000_3521);
    run_and_check("R5 limit eight ok", 2, 1024, 32'h0000_0088);
    run_and_check("R6 R5 nine bad", 3, 1536, 32'h0000_0A92);
  endtask

  task automatic t_sym4();
    run_and_check("R4 mask", 1, 1024, 32'h0000_00BC);
    run_and_check("R4 five bad", 1, 1024, 32'h0000_0025);
  endtask

  task automatic t_sticky();
    int held;
    run_and_check("R8 bad run", 2, 1024, 32'h0000_00F3);
    held = int'(corr_total);
    repeat (3) @(negedge clk);
    chk(uncorrectable == 1'b1, "R8 flag held", int'(uncorrectable), 1);
    chk(int'(corr_total) == held, "R8 total held", int'(corr_total), held);
    run_and_check("R8 cleared by start", 2, 512, 32'h0000_0001);
  endtask

  task automatic t_page_size();
    run_and_check("R2 upper fields ignored", 2, 512, 32'hFFFF_FFF3);
    run_and_check("R2 clamp high", 2, 8192, 32'h1111_1111);
    run_and_check("R2 zero bytes", 2, 0, 32'h0000_0027);
    run_and_check("R2 odd bytes", 2, 1500, 32'h0000_0F21);
  endtask

  task automatic t_two_code();
    run_and_check("R7 main two", 0, 2048, 32'h0000_0002);
    run_and_check("R7 spare two", 0, 2048, 32'h0000_0008);
    run_and_check("R7 single bits", 0, 2048, 32'h0000_0005);
    run_and_check("R7 wide spare", 0, 2048, 32'h0000_0042);
  endtask

  task automatic t_restart();
    int et, eb;
    bit early = 0;
    launch(2, 4096, 32'h9999_9999);
    @(negedge clk); start = 1'b0; if (done) early = 1;
    @(negedge clk); if (done) early = 1;
    model(2, 1024, 32'h0000_0064, et, eb);
    launch(2, 1024, 32'h0000_0064);
    await_done();
    chk(!early, "R9 no done from abandoned walk", int'(early), 0);
    chk(got_lat == 3, "R9 latency", got_lat, 3);
    chk(got_tot == et, "R9 total", got_tot, et);
    chk(got_bad == eb, "R9 flag", got_bad, eb);
  endtask

  initial begin
    #50000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_sym8();
    t_sym4();
    t_sticky();
    t_page_size();
    t_two_code();
    t_restart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule